// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test port of a synchronous memory device. It is clocked by its own test clock, walks the standard sixteen-state test controller from the mode-select input, and holds a 3-bit instruction. The instruction picks one data path between serial in and serial out: a 1-bit pass-through cell, a 32-bit identification register, or a boundary register. The boundary register has one cell per sampled pin and extra cells that map to no pin.

Pin values arrive on a parallel bus. The block drives two controls toward the pin ring. `ovr_en` makes the output drivers present the boundary update stage. `hiz` floats every device output. Neither control touches the functional inputs. Serial out changes only on the falling test-clock edge, and its enable is high only while a register is being shifted. The update stages also change on the falling edge.

Top module: `scan_tap`

## Requirements
- R1: After `trst_n` is asserted, and on every falling edge while the controller is in Test-Logic-Reset, the instruction becomes IDCODE (3'b001).
- R2: Five consecutive rising edges with `tms`=1 bring the controller to Test-Logic-Reset from any state. This reverts the instruction to IDCODE and clears `ovr_en` and `hiz`.
- R3: Capture-IR loads 3'b001 into the instruction shifter. Shift-IR shifts it out least significant bit first, so the bits read are 1, 0, 0.
- R4: Under IDCODE (3'b001), Capture-DR loads `ID_VALUE` with bit 0 forced to 1. Shift-DR shifts those 32 bits out least significant bit first.
- R5: BYPASS (3'b111) and the reserved codes 3'b011, 3'b101 and 3'b110 select a 1-bit cell. That cell captures 0, so serial out is the captured 0 followed by serial in delayed by one shift.
- R6: Under SAMPLE/PRELOAD (3'b100), Capture-DR loads `pin_sample` into cells 0 to PIN_CNT-1 and `CELL_DEF` bits into the higher cells. The register is shifted out from cell 0. Update-DR loads the shifted value into the update stage, and `ovr_en` stays 0.
- R7: EXTEST is code 3'b000 and sets `ovr_en`=1. Capture-DR behaves as in R6. The shifted value reaches `bs_drive` on the falling edge in Update-DR and not before.
- R8: SAMPLE-Z (3'b010) sets `hiz`=1 and `ovr_en`=0, and places the boundary register, captured as in R6, between serial in and serial out.
- R9: `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR. `tdo` changes only on falling test-clock edges.
- R10: `trst_n`=0 resets the block at once, without a clock edge. It clears `ovr_en`, `hiz`, `tdo_en` and `bs_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Controller mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| pin_sample | input | PIN_CNT | Parallel sampled input and I/O pin values |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_en | output | 1 | Serial out drive enable |
| bs_drive | output | BSR_LEN | Boundary update stage toward the output drivers |
| ovr_en | output | 1 | Output drivers take `bs_drive` |
| hiz | output | 1 | Float all device outputs |

## Verification
On every rising edge, the assertions check these properties:
- Five ones on `tms` end in Test-Logic-Reset.
- Test-Logic-Reset restores IDCODE.
- Capture-IR loads the fixed pattern.
- `tdo_en` follows the shift states.
- An EXTEST Update-DR copies the boundary shifter to `bs_drive`.

Only the bench scenarios can show the serial content of each data path. That covers the identification value, the bypass delay, the reserved codes, the pin and default capture order, and preload followed by EXTEST. The scenarios also show that `bs_drive` is still old just after the rising edge into Update-DR, and that reset acts without a clock edge.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int BSR_LEN = 16,
  parameter int PIN_CNT = 12,
  parameter logic [BSR_LEN-1:0] CELL_DEF = 16'hA000,
  parameter logic [31:0] ID_VALUE = 32'h1A2B3C4C
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [PIN_CNT-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_en,
  output logic [BSR_LEN-1:0] bs_drive,
  output logic               ovr_en,
  output logic               hiz
);
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UP_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UP_IR
  } st_t;

  localparam logic [2:0] OP_EXTEST = 3'b000;
  localparam logic [2:0] OP_ID     = 3'b001;
  localparam logic [2:0] OP_HIZ    = 3'b010;
  localparam logic [2:0] OP_SAMPLE = 3'b100;

  st_t state, nxt;
  logic [2:0] ir, ir_sr;
  logic byp;
  logic [31:0] id_sr;
  logic [BSR_LEN-1:0] bsr_sr, bsr_cap;

  wire sel_id  = (ir == OP_ID);
  wire sel_bsr = (ir == OP_EXTEST) || (ir == OP_SAMPLE) || (ir == OP_HIZ);
  wire sel_byp = !sel_id && !sel_bsr;
  wire dr_out  = sel_id ? id_sr[0] : (sel_bsr ? bsr_sr[0] : byp);

  assign ovr_en   = (ir == OP_EXTEST);
  assign hiz      = (ir == OP_HIZ);

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i < PIN_CNT) begin : g_pin
      assign bsr_cap[i] = pin_sample[i];
    end else begin : g_def
      assign bsr_cap[i] = CELL_DEF[i];
    end
  end

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UP_DR  : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UP_DR  : SH_DR;
      UP_DR:   nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UP_IR  : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UP_IR  : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state  <= TLR;
      ir_sr  <= '0;
      byp    <= 1'b0;
      id_sr  <= '0;
      bsr_sr <= '0;
    end else begin
      state <= nxt;
      case (state)
        CAP_IR: ir_sr <= 3'b001;
        SH_IR:  ir_sr <= {tdi, ir_sr[2:1]};
        CAP_DR: begin
          if (sel_byp) byp <= 1'b0;
          if (sel_id)  id_sr <= ID_VALUE | 32'd1;
          if (sel_bsr) bsr_sr <= bsr_cap;
        end
        SH_DR: begin
          if (sel_byp) byp <= tdi;
          if (sel_id)  id_sr <= {tdi, id_sr[31:1]};
          if (sel_bsr) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir       <= OP_ID;
      tdo      <= 1'b0;
      tdo_en   <= 1'b0;
      bs_drive <= '0;
    end else begin
      if (state == TLR) ir <= OP_ID;
      else if (state == UP_IR) ir <= ir_sr;
      if (state == UP_DR && (ir == OP_EXTEST || ir == OP_SAMPLE)) bs_drive <= bsr_sr;
      tdo_en <= (state == SH_IR) || (state == SH_DR);
      tdo    <= (state == SH_IR) ? ir_sr[0] : dr_out;
    end
  end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk #(
  parameter int BSR_LEN = 16
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input logic [3:0]         state,
  input logic [2:0]         ir,
  input logic [2:0]         ir_sr,
  input logic               tdo_en,
  input logic [BSR_LEN-1:0] bsr_sr,
  input logic [BSR_LEN-1:0] bs_drive
);
  localparam logic [3:0] S_TLR = 4'd0, S_SH_DR = 4'd4, S_UP_DR = 4'd8,
                         S_CAP_IR = 4'd10, S_SH_IR = 4'd11;

  p_tlr_five_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == S_TLR));

  p_tlr_idcode_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> (ir == 3'b001));

  p_cap_ir_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (ir_sr == 3'b001));

  p_tdo_en_r9: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (state == S_SH_IR || state == S_SH_DR));

  p_extest_upd_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UP_DR && ir == 3'b000) |=> (bs_drive == $past(bsr_sr)));
endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir(ir),
  .ir_sr(ir_sr), .tdo_en(tdo_en), .bsr_sr(bsr_sr), .bs_drive(bs_drive)
);

// File: tb/scan_tap_test.sv
`timescale 1ns/1ps
module scan_tap_test;
  localparam int BL = 16, PC = 12;
  localparam logic [31:0] IDV = 32'h1A2B3C4C;
  localparam logic [3:0] DEF_HI = 4'hA;

  logic tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic [PC-1:0] pin_sample = '0;
  logic tdo, tdo_en, ovr_en, hiz;
  logic [BL-1:0] bs_drive;
  int n_chk = 0, n_fail = 0;

  always #4 tck = ~tck;

  scan_tap #(.BSR_LEN(BL), .PIN_CNT(PC), .CELL_DEF(16'hA000), .ID_VALUE(IDV)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_sample(pin_sample),
    .tdo(tdo), .tdo_en(tdo_en), .bs_drive(bs_drive), .ovr_en(ovr_en), .hiz(hiz));

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic e);
    o = tdo; e = tdo_en; tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic go_rti();
    logic o, e;
    for (int i = 0; i < 5; i++) step(1, 0, o, e);
    step(0, 0, o, e);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    logic o, e;
    step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, e);
      cap[i] = o;
    end
    step(1, 0, o, e); step(0, 0, o, e);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                          output logic en_all, output logic [BL-1:0] pre_upd);
    logic o, e;
    dout = '0; en_all = 1;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, e);
      dout[i] = o; en_all &= e;
    end
    tms = 1; @(posedge tck); #1; pre_upd = bs_drive;
    @(negedge tck); #1;
    step(0, 0, o, e);
  endtask

  task automatic t_reset();
    logic [63:0] d; logic en; logic [BL-1:0] p;
    check(tdo_en == 0 && ovr_en == 0 && hiz == 0 && bs_drive == 0, "R10 reset outputs",
          {tdo_en, ovr_en, hiz, bs_drive}, 0);
    go_rti();
    check(tdo_en == 0, "R9 tdo_en low in idle", tdo_en, 0);
    shift_dr(32, 64'h0, d, en, p);
    check(d[31:0] == (IDV | 32'd1), "R1 R4 idcode after reset", d[31:0], IDV | 32'd1);
    check(en == 1, "R9 tdo_en high in Shift-DR", en, 1);
  endtask

  task automatic t_ir_cap();
    logic [2:0] c;
    load_ir(3'b111, c);
    check(c == 3'b001, "R3 capture-IR pattern", c, 3'b001);
  endtask

  task automatic t_bypass(input logic [2:0] code);
    logic [2:0] c; logic [63:0] d; logic en; logic [BL-1:0] p;
    logic [7:0] pat = 8'b1011_0110;
    load_ir(code, c);
    shift_dr(8, {56'h0, pat}, d, en, p);
    check(d[7:0] == {pat[6:0], 1'b0}, $sformatf("R5 bypass code %b", code), d[7:0], {pat[6:0], 1'b0});
  endtask

  task automatic t_sample_extest();
    logic [2:0] c; logic [63:0] d; logic en; logic [BL-1:0] p;
    logic [BL-1:0] pre = 16'h5E71, q = 16'hC39A;
    pin_sample = 12'hA5C;
    load_ir(3'b100, c);
    shift_dr(BL, {48'h0, pre}, d, en, p);
    check(d[BL-1:0] == {DEF_HI, 12'hA5C}, "R6 sample capture", d[BL-1:0], {DEF_HI, 12'hA5C});
    check(ovr_en == 0 && hiz == 0, "R6 no override in sample", {ovr_en, hiz}, 0);
    check(bs_drive == pre, "R6 preload update stage", bs_drive, pre);
    load_ir(3'b000, c);
    check(ovr_en == 1 && hiz == 0, "R7 extest override", {ovr_en, hiz}, 2'b10);
    check(bs_drive == pre, "R7 extest drives preload", bs_drive, pre);
    pin_sample = 12'h3C6;
    shift_dr(BL, {48'h0, q}, d, en, p);
    check(d[BL-1:0] == {DEF_HI, 12'h3C6}, "R7 extest capture", d[BL-1:0], {DEF_HI, 12'h3C6});
    check(p == pre, "R7 no update at rising edge", p, pre);
    check(bs_drive == q, "R7 update at falling edge", bs_drive, q);
  endtask

  task automatic t_hiz_and_tlr();
    logic [2:0] c; logic [63:0] d; logic en; logic [BL-1:0] p;
    pin_sample = 12'h0F3;
    load_ir(3'b010, c);
    check(hiz == 1 && ovr_en == 0, "R8 samplez controls", {hiz, ovr_en}, 2'b10);
    shift_dr(BL, 64'h0, d, en, p);
    check(d[BL-1:0] == {DEF_HI, 12'h0F3}, "R8 samplez scan path", d[BL-1:0], {DEF_HI, 12'h0F3});
    go_rti();
    check(hiz == 0 && ovr_en == 0, "R2 tms reset clears controls", {hiz, ovr_en}, 0);
    shift_dr(32, 64'h0, d, en, p);
    check(d[31:0] == (IDV | 32'd1), "R2 R1 idcode after tms reset", d[31:0], IDV | 32'd1);
  endtask

  task automatic t_tdo_edge();
    logic [2:0] c; logic o, e;
    load_ir(3'b111, c);
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    check(tdo == 0, "R9 bypass first bit", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check(tdo == 0, "R9 tdo held after rising edge", tdo, 0);
    @(negedge tck); #1;
    check(tdo == 1, "R9 tdo moves at falling edge", tdo, 1);
    step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e);
  endtask

  task automatic t_async_reset();
    logic [2:0] c; logic [63:0] d; logic en; logic [BL-1:0] p;
    load_ir(3'b000, c);
    shift_dr(BL, 64'h0000_0000_0000_FFFF, d, en, p);
    check(ovr_en == 1 && bs_drive == 16'hFFFF, "R10 extest armed", {ovr_en, bs_drive}, {1'b1, 16'hFFFF});
    #1 trst_n = 0; #1;
    check(ovr_en == 0 && bs_drive == 0 && hiz == 0, "R10 async reset", {ovr_en, bs_drive}, 0);
    @(negedge tck); #1 trst_n = 1;
    go_rti();
  endtask

  initial begin
    repeat (3) @(negedge tck);
    #1 trst_n = 1;
    t_reset();
    t_ir_cap();
    t_bypass(3'b111); t_bypass(3'b011); t_bypass(3'b101); t_bypass(3'b110);
    t_sample_extest();
    t_hiz_and_tlr();
    t_tdo_edge();
    t_async_reset();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule